// File: doc/BRIEF.md
# Byte-Loaded Reload Down-Counter

This block is a down-counting timer whose reload value is written over a narrow processor bus, one byte per access. A count-enable tick steps the counter down by one while the timer runs. When the counter steps past zero it reloads itself from the reload register and raises a one-clock underflow pulse. The counter is also loaded from the reload register on each rising edge of the start control.

The reload register is write-only. The bus address that writes it is the same address that reads the live counter. Software writes the upper byte first, and that byte waits in a staging latch. The next lower-byte write moves the staged byte and the new lower byte into the active reload value together. A wide write moves the whole value in one cycle. Reads are coherent: reading the upper byte also captures the lower byte, and a following lower-byte read returns the captured byte.

Bus writes and read requests are accepted on every cycle, so ready is high at all times and the bus has no back-pressure. `rd_valid` goes high exactly one clock after `rd_en`, with `rd_data` valid in that same cycle. The consumer must take the read result in that cycle, because the block does not hold it.

Top module: `reload_down_timer`

## Requirements
- R1: After reset, the counter, the active reload value and the staging latch are all zero, and `running`, `underflow` and `rd_valid` are low.
- R2: A write with `wr_hi`=1 stores `wr_data[7:0]` in the staging latch only. The active reload value does not change, so later start loads and underflow reloads still use the previous value.
- R3: A write with `wr_hi`=0 and `wr_wide`=0 sets the active reload value to {staged byte, `wr_data[7:0]`}.
- R4: A write with `wr_hi`=0 and `wr_wide`=1 sets the active reload value to all 16 bits of `wr_data` in a single cycle.
- R5: On a clock where `start` is high and was low on the previous clock, the counter is loaded with the active reload value and `running` goes high. Holding `start` high does not load the counter again.
- R6: While running, each clock with `tick`=1 lowers the counter by one. Clocks with `tick`=0 leave it unchanged.
- R7: A tick while the counter is 0x0000 reloads the counter from the active reload value. On the next clock, `underflow` is high for exactly one cycle.
- R8: While `start` is low, `running` is low and the counter holds its value, including when ticks arrive.
- R9: A reload write while the timer is counting does not change the current count. The new value is first used at the next underflow or start load.
- R10: The clock after `rd_en`, `rd_valid` is high. If `rd_hi`=1, `rd_data` is counter bits 15:8, and counter bits 7:0 are captured at that same instant. A later `rd_hi`=0 read returns the captured byte, even if the counter has moved on.
- R11: An `rd_hi`=0 read with no capture pending returns the live counter bits 7:0. Any `rd_hi`=0 read clears a pending capture.
- R12: If a start rising edge and a tick arrive on the same clock, only the load happens. The counter equals the reload value, not one less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe for the reload register |
| wr_hi | input | 1 | Byte select: 1 = upper byte, 0 = lower byte |
| wr_wide | input | 1 | With `wr_hi`=0, write all 16 bits at once |
| wr_data | input | 16 | Write data; byte writes use bits 7:0 |
| rd_en | input | 1 | Read request for the counter |
| rd_hi | input | 1 | Read byte select: 1 = upper, 0 = lower |
| rd_valid | output | 1 | Read result valid, one clock after `rd_en` |
| rd_data | output | 8 | Read result byte |
| start | input | 1 | Run control: rising edge loads, level enables counting |
| tick | input | 1 | Count-enable pulse |
| running | output | 1 | Timer is counting |
| underflow | output | 1 | One-clock pulse after a reload caused by underflow |

## Verification
The bench builds the block with its default 8-bit byte width, which gives a 16-bit counter. It loads small reload values such as 2 and 5, so underflow and reload are reached within a few ticks. Because the counter has two byte lanes, it also exercises the staged upper byte, the coherent upper-then-lower read, and the collision of a start edge with a tick.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  typedef enum logic {
    LANE_LO = 1'b0,
    LANE_HI = 1'b1
  } lane_e;
endpackage

// File: rtl/rtmr_reload.sv
module rtmr_reload
  import rtmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  lane_e               wr_lane,
  input  logic                wr_wide,
  input  logic [2*BYTE_W-1:0] wr_data,
  output logic [2*BYTE_W-1:0] reload_o
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] stage_q;
  logic [CNT_W-1:0]  reload_q;

  // staged upper byte commits only with a lower-lane write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      reload_q <= '0;
    end else if (wr_en) begin
      if (wr_lane == LANE_HI) begin
        stage_q <= wr_data[BYTE_W-1:0];
      end else if (wr_wide) begin
        reload_q <= wr_data;
      end else begin
        reload_q <= {stage_q, wr_data[BYTE_W-1:0]};
      end
    end
  end

  assign reload_o = reload_q;
endmodule

// File: rtl/rtmr_counter.sv
module rtmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             uf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             uf_q;
  logic             load_edge;
  logic             step;
  logic             at_zero;

  assign load_edge = start & ~run_q;
  assign step      = start & run_q & tick;
  assign at_zero   = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      uf_q  <= 1'b0;
    end else begin
      run_q <= start;
      uf_q  <= step & at_zero;
      if (load_edge) begin
        cnt_q <= reload;
      end else if (step) begin
        cnt_q <= at_zero ? reload : cnt_q - CNT_W'(1);
      end
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
  assign uf_o  = uf_q;
endmodule

// File: rtl/rtmr_readback.sv
module rtmr_readback
  import rtmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  lane_e               rd_lane,
  input  logic [2*BYTE_W-1:0] cnt,
  output logic                rd_valid,
  output logic [BYTE_W-1:0]   rd_data
);
  logic [BYTE_W-1:0] snap_q;
  logic              snap_vld_q;
  logic [BYTE_W-1:0] data_q;
  logic              vld_q;
  logic [BYTE_W-1:0] lane_val [2];

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_lane
      assign lane_val[g] = cnt[g*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q     <= '0;
      snap_vld_q <= 1'b0;
      data_q     <= '0;
      vld_q      <= 1'b0;
    end else begin
      vld_q <= rd_en;
      if (rd_en) begin
        if (rd_lane == LANE_HI) begin
          data_q     <= lane_val[1];
          snap_q     <= lane_val[0];
          snap_vld_q <= 1'b1;
        end else begin
          data_q     <= snap_vld_q ? snap_q : lane_val[0];
          snap_vld_q <= 1'b0;
        end
      end
    end
  end

  assign rd_valid = vld_q;
  assign rd_data  = data_q;
endmodule

// File: rtl/reload_down_timer.sv
module reload_down_timer
  import rtmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_hi,
  input  logic                wr_wide,
  input  logic [2*BYTE_W-1:0] wr_data,
  input  logic                rd_en,
  input  logic                rd_hi,
  output logic                rd_valid,
  output logic [BYTE_W-1:0]   rd_data,
  input  logic                start,
  input  logic                tick,
  output logic                running,
  output logic                underflow
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] cnt_val;
  lane_e            wr_lane;
  lane_e            rd_lane;

  assign wr_lane = lane_e'(wr_hi);
  assign rd_lane = lane_e'(rd_hi);

  rtmr_reload #(.BYTE_W(BYTE_W)) u_reload (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_lane  (wr_lane),
    .wr_wide  (wr_wide),
    .wr_data  (wr_data),
    .reload_o (reload_val)
  );

  rtmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .tick   (tick),
    .reload (reload_val),
    .cnt_o  (cnt_val),
    .run_o  (running),
    .uf_o   (underflow)
  );

  rtmr_readback #(.BYTE_W(BYTE_W)) u_readback (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_lane  (rd_lane),
    .cnt      (cnt_val),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/rtmr_checker.sv
module rtmr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_hi,
  input logic             rd_en,
  input logic             rd_valid,
  input logic             start,
  input logic             tick,
  input logic             running,
  input logic             underflow,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload
);
  assert_stage_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi) |=> $stable(reload));

  assert_load_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !running) |=> (cnt == $past(reload)) && running);

  assert_step_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && running && tick && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));

  assert_uf_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && running && tick && cnt == '0) |=> underflow && cnt == $past(reload));

  assert_uf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(tick) && $past(running));

  assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(cnt) && !running);

  assert_rd_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_rd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

bind reload_down_timer rtmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_hi     (wr_hi),
  .rd_en     (rd_en),
  .rd_valid  (rd_valid),
  .start     (start),
  .tick      (tick),
  .running   (running),
  .underflow (underflow),
  .cnt       (cnt_val),
  .reload    (reload_val)
);

// File: tb/reload_down_timer_tb.sv
`timescale 1ns/1ps
module reload_down_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_hi = 1'b0, wr_wide = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0, rd_hi = 1'b0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        start = 1'b0, tick = 1'b0;
  logic        running, underflow;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  reload_down_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_wide(wr_wide),
    .wr_data(wr_data), .rd_en(rd_en), .rd_hi(rd_hi), .rd_valid(rd_valid),
    .rd_data(rd_data), .start(start), .tick(tick), .running(running),
    .underflow(underflow)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid && !done) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected rd_valid", 16'h1, 16'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, {8'h00, rd_data}, {8'h00, e.val});
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(bit hi, logic [7:0] v);
    wr_en = 1'b1; wr_hi = hi; wr_wide = 1'b0; wr_data = {8'h00, v};
    @(negedge clk);
    wr_en = 1'b0; wr_hi = 1'b0;
  endtask

  task automatic wr_full(logic [15:0] v);
    wr_en = 1'b1; wr_hi = 1'b0; wr_wide = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_wide = 1'b0;
  endtask

  task automatic rd(bit hi, logic [7:0] v, string tag);
    exp_t e;
    e.val = v; e.tag = tag;
    exp_q.push_back(e);
    rd_en = 1'b1; rd_hi = hi;
    @(negedge clk);
    rd_en = 1'b0; rd_hi = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic set_start(bit v);
    start = v;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 running", {15'h0, running}, 16'h0);
    check("R1 underflow", {15'h0, underflow}, 16'h0);
    check("R1 rd_valid", {15'h0, rd_valid}, 16'h0);
    rd(1'b1, 8'h00, "R1 cnt hi");
    rd(1'b0, 8'h00, "R1 cnt lo");

    // R2 upper byte only: start loads the old value 0
    wr_byte(1'b1, 8'h12);
    set_start(1'b1);
    check("R5 running", {15'h0, running}, 16'h1);
    rd(1'b1, 8'h00, "R2 hi");
    rd(1'b0, 8'h00, "R2 lo");
    set_start(1'b0);

    // R3 lower commit, R5 load
    wr_byte(1'b0, 8'h34);
    set_start(1'b1);
    rd(1'b1, 8'h12, "R3 hi");
    rd(1'b0, 8'h34, "R3 lo");

    // R6 decrement
    ticks(3);
    idle(2);
    rd(1'b1, 8'h12, "R6 hi");
    rd(1'b0, 8'h31, "R6 lo");

    // R10 coherent read, R11 live read
    rd(1'b1, 8'h12, "R10 hi");
    ticks(2);
    rd(1'b0, 8'h31, "R10 snapshot lo");
    rd(1'b0, 8'h2F, "R11 live lo");

    // R5 held start does not reload
    idle(4);
    rd(1'b0, 8'h2F, "R5 held lo");

    // R9 write while running leaves the count
    wr_full(16'h0002);
    rd(1'b1, 8'h12, "R9 hi");
    rd(1'b0, 8'h2F, "R9 lo");

    // R8 stop holds
    set_start(1'b0);
    ticks(3);
    check("R8 running", {15'h0, running}, 16'h0);
    rd(1'b1, 8'h12, "R8 hi");
    rd(1'b0, 8'h2F, "R8 lo");

    // R4 wide value loaded at start
    set_start(1'b1);
    rd(1'b1, 8'h00, "R4 hi");
    rd(1'b0, 8'h02, "R4 lo");

    // R7 underflow
    ticks(1); check("R7 no uf at 1", {15'h0, underflow}, 16'h0);
    ticks(1); check("R7 no uf at 0", {15'h0, underflow}, 16'h0);
    ticks(1); check("R7 uf pulse", {15'h0, underflow}, 16'h1);
    idle(1);  check("R7 uf one cycle", {15'h0, underflow}, 16'h0);
    rd(1'b1, 8'h00, "R7 reload hi");
    rd(1'b0, 8'h02, "R7 reload lo");

    // R9 new value used at next underflow
    wr_full(16'h0005);
    ticks(3);
    check("R9 uf", {15'h0, underflow}, 16'h1);
    rd(1'b0, 8'h05, "R9 new reload");

    // R2 upper only while running: reload stays 5
    wr_byte(1'b1, 8'hAB);
    ticks(6);
    check("R2 uf", {15'h0, underflow}, 16'h1);
    rd(1'b1, 8'h00, "R2 reload hi");
    rd(1'b0, 8'h05, "R2 reload lo");

    // R12 start edge with tick: load only
    set_start(1'b0);
    ticks(2);
    start = 1'b1; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    rd(1'b0, 8'h05, "R12 lo");

    idle(3);
    check("R10 queue drained", 16'(exp_q.size()), 16'h0);
    finish_run();
  end
endmodule